// File: doc/BRIEF.md
# Palette Table with Host Register Access

This block holds a 256-entry palette of 16-bit RGB565 colours and turns 8-bit pixel indices from a display pipeline into colour words. A host processor reaches the same storage through three 16-bit registers: a control word, a write-data word and a read-data word. A single ownership bit in the control word decides who may use the table. While the host owns it, entries can be read and written and the display path is blocked. While the display owns it, the display path does indexed lookups and host entry accesses are refused.

Host entry accesses are paced by a busy flag. A write to the write-data register stores one entry and raises busy for one cycle. A host read is started by a trigger bit that software sets and must later clear. The read takes two busy cycles, and the result lands in the read-data register on the cycle busy drops. The display side is a stream input: `pix_ready` is tied high, so every index offered with `pix_valid` is taken on that clock edge. Exactly one cycle later `col_valid` pulses with the colour. The output side has no ready signal, so the consumer must take every result in the cycle it appears.

Top module: `palette_table`

## Requirements
- R1: After reset the control, write-data and read-data registers read 0x0000, busy is 0, the table is disabled and the display side owns it.
- R2: Writes to control bits 13:10 and to the busy bit 14 have no effect, and bits 13:10 always read as zero.
- R3: `host_sel` picks the register: 0 is control, 1 is write-data, 2 is read-data (writes ignored), and 3 reads 0x0000. The control layout is: bit 15 is table enable, bit 14 is busy, bit 9 is read trigger, bit 8 is host ownership, and bits 7:0 are the entry address.
- R4: A write to register 1 while host ownership is 1 and busy is 0 stores the data at the addressed entry. Busy then reads 1 for exactly the next cycle.
- R5: A 0-to-1 change of the read trigger while the host owns the table holds busy at 1 for two cycles. The read-data register takes the addressed entry on the cycle busy returns to 0 and does not change at any other time.
- R6: The trigger does not clear itself. While it stays at 1, no further read happens, even when the address changes. A new read needs the trigger cleared and then set again.
- R7: While host ownership is 0, writes to register 1 leave the table unchanged and a set trigger starts no read. A trigger set while ownership was 0 stays spent after ownership is set.
- R8: With the table enabled and the display owning it, an index taken with `pix_valid` gives `col_valid` high one cycle later, with `col_data` equal to the stored entry.
- R9: With the table disabled and the display owning it, `col_data` is the index zero-extended to 16 bits.
- R10: While the host owns the table, every display result is 0x0000.
- R11: A write to register 1 that arrives while busy is 1 is ignored: the table entry and the write-data register keep their values.
- R12: `pix_ready` is always 1, so the display input is never stalled, in any ownership or busy state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the register chosen by host_sel |
| host_sel | input | 2 | Register select (0 control, 1 write-data, 2 read-data) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read-back of the selected register (combinational) |
| pix_valid | input | 1 | Display index valid |
| pix_ready | output | 1 | Display index accepted (always 1) |
| pix_index | input | 8 | Display pixel index |
| col_valid | output | 1 | Colour result valid, one cycle after the index |
| col_data | output | 16 | Colour result |

## Verification
Some rules are checked by assertions on every cycle: the busy pulse lengths for host writes and reads, the read-data register changing only when busy falls, no busy cycle starting while the display owns the table, the fixed one-cycle result latency, and the pass-through and blocked output values. Other behaviour needs the bench's scenarios. These are the actual entry contents seen by both ports, the one-shot trigger across address changes and ownership changes, writes dropped during busy, and the reserved-bit read-back.

// File: rtl/palette_pkg.sv
package palette_pkg;

  // Control word field positions (the host software decodes these)
  localparam int CTL_BIT_EN   = 15;
  localparam int CTL_BIT_BUSY = 14;
  localparam int CTL_BIT_TRIG = 9;
  localparam int CTL_BIT_OWN  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WR   = 2'd1,
    HS_RD1  = 2'd2,
    HS_RD2  = 2'd3
  } hs_state_e;

  typedef enum logic [1:0] {
    LK_TABLE = 2'd0,
    LK_PASS  = 2'd1,
    LK_HELD  = 2'd2
  } lk_mode_e;

endpackage

// File: rtl/palette_store.sv
module palette_store #(
  parameter int IDX_W = 8,
  parameter int COL_W = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [COL_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [COL_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COL_W-1:0] mem [DEPTH];

  // One write port, one registered read port; the read returns the old word
  // when both hit the same entry in one cycle.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/palette_host_regs.sv
module palette_host_regs
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int COL_W = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic [COL_W-1:0] mem_rdata,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic [COL_W-1:0] mem_wdata,
  output logic [IDX_W-1:0] host_raddr,
  output logic             tab_en,
  output logic             host_own,
  output logic             busy
);

  logic             en_q, trig_q, own_q, trig_used_q;
  logic [IDX_W-1:0] addr_q, rd_addr_q;
  logic [COL_W-1:0] wdata_q, rdata_q;
  hs_state_e        st_q, st_d;

  logic ctrl_wr, data_wr, wr_go, trig_seen, rd_go;
  logic [REG_W-1:0] ctrl_view;
  logic ctrl_unused;

  assign ctrl_unused = ^{host_wdata[13:10], host_wdata[CTL_BIT_BUSY]};

  assign ctrl_wr   = host_wr && (host_sel == SEL_CTRL);
  assign data_wr   = host_wr && (host_sel == SEL_WDATA);
  assign busy      = (st_q != HS_IDLE);
  assign wr_go     = data_wr && own_q && !busy;
  // A fresh trigger is consumed once, whether or not the host owns the table.
  assign trig_seen = trig_q && !trig_used_q && !busy && !wr_go;
  assign rd_go     = trig_seen && own_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: begin
        if (wr_go)      st_d = HS_WR;
        else if (rd_go) st_d = HS_RD1;
      end
      HS_WR:   st_d = HS_IDLE;
      HS_RD1:  st_d = HS_RD2;
      HS_RD2:  st_d = HS_IDLE;
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      trig_q      <= 1'b0;
      own_q       <= 1'b0;
      addr_q      <= '0;
      rd_addr_q   <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      trig_used_q <= 1'b0;
      st_q        <= HS_IDLE;
    end else begin
      if (ctrl_wr) begin
        en_q   <= host_wdata[CTL_BIT_EN];
        trig_q <= host_wdata[CTL_BIT_TRIG];
        own_q  <= host_wdata[CTL_BIT_OWN];
        addr_q <= host_wdata[IDX_W-1:0];
      end
      if (data_wr && !busy) wdata_q <= host_wdata[COL_W-1:0];
      if (!trig_q)        trig_used_q <= 1'b0;
      else if (trig_seen) trig_used_q <= 1'b1;
      if (rd_go) rd_addr_q <= addr_q;
      if (st_q == HS_RD2) rdata_q <= mem_rdata;
      st_q <= st_d;
    end
  end

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[CTL_BIT_EN]   = en_q;
    ctrl_view[CTL_BIT_BUSY] = busy;
    ctrl_view[CTL_BIT_TRIG] = trig_q;
    ctrl_view[CTL_BIT_OWN]  = own_q;
    ctrl_view[IDX_W-1:0]    = addr_q;
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_sel)
      SEL_CTRL:  host_rdata = ctrl_view;
      SEL_WDATA: host_rdata[COL_W-1:0] = wdata_q;
      SEL_RDATA: host_rdata[COL_W-1:0] = rdata_q;
      default:   host_rdata = '0;
    endcase
  end

  assign mem_we     = wr_go;
  assign mem_waddr  = addr_q;
  assign mem_wdata  = host_wdata[COL_W-1:0];
  assign host_raddr = rd_addr_q;
  assign tab_en     = en_q;
  assign host_own   = own_q;

  AST_WR_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> busy ##1 !busy); // R4
  AST_RD_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> busy ##1 busy ##1 !busy); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rdata_q)); // R5
  AST_NO_ACCESS_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_q && !busy) |=> !busy); // R7

endmodule

// File: rtl/palette_lookup.sv
module palette_lookup
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int COL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_index,
  output logic             pix_ready,
  input  logic             tab_en,
  input  logic             host_own,
  input  logic [COL_W-1:0] mem_rdata,
  output logic             col_valid,
  output logic [COL_W-1:0] col_data
);

  logic             v_q;
  logic [IDX_W-1:0] idx_q;
  lk_mode_e         mode_q, mode_d;

  assign pix_ready = 1'b1;

  always_comb begin
    if (host_own)     mode_d = LK_HELD;
    else if (!tab_en) mode_d = LK_PASS;
    else              mode_d = LK_TABLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      idx_q  <= '0;
      mode_q <= LK_PASS;
    end else begin
      v_q <= pix_valid;
      if (pix_valid) begin
        idx_q  <= pix_index;
        mode_q <= mode_d;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      LK_TABLE: col_data = mem_rdata;
      LK_PASS:  col_data = COL_W'(idx_q);
      default:  col_data = '0;
    endcase
  end

  assign col_valid = v_q;

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> col_valid); // R8
  AST_BYPASS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(!tab_en && !host_own)) |-> (col_data == COL_W'($past(pix_index)))); // R9
  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(host_own)) |-> (col_data == '0)); // R10

endmodule

// File: rtl/palette_table.sv
module palette_table
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int COL_W = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [IDX_W-1:0] pix_index,
  output logic             col_valid,
  output logic [COL_W-1:0] col_data
);

  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr, host_raddr, mem_raddr;
  logic [COL_W-1:0] mem_wdata, mem_rdata;
  logic             tab_en, host_own, busy;

  // The single read port follows whichever side owns the table.
  assign mem_raddr = host_own ? host_raddr : pix_index;

  palette_host_regs #(.IDX_W(IDX_W), .COL_W(COL_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .host_raddr (host_raddr),
    .tab_en     (tab_en),
    .host_own   (host_own),
    .busy       (busy)
  );

  palette_store #(.IDX_W(IDX_W), .COL_W(COL_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  palette_lookup #(.IDX_W(IDX_W), .COL_W(COL_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_index (pix_index),
    .pix_ready (pix_ready),
    .tab_en    (tab_en),
    .host_own  (host_own),
    .mem_rdata (mem_rdata),
    .col_valid (col_valid),
    .col_data  (col_data)
  );

  AST_OWNED_NO_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && col_valid) |-> (col_data == '0)); // R10

endmodule

// File: tb/palette_table_tb.sv
module palette_table_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_index = '0;
  logic        col_valid;
  logic [15:0] col_data;

  always #5 clk = ~clk;

  palette_table u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_index(pix_index), .col_valid(col_valid),
    .col_data(col_data)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] tbl_m [256];
  bit en_m = 1'b0;
  bit own_m = 1'b0;
  logic [15:0] exp_q [$];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_sel = 2'd3;
  endtask

  task automatic bus_rd(logic [1:0] sel, output logic [15:0] v);
    host_sel = sel;
    #1;
    v = host_rdata;
    host_sel = 2'd3;
  endtask

  task automatic set_ctrl(bit en, bit trig, bit own, logic [7:0] a);
    bus_wr(2'd0, {en, 1'b0, 4'b0000, trig, own, a});
    en_m = en; own_m = own;
  endtask

  task automatic chk_busy(string tag, bit exp);
    logic [15:0] v;
    bus_rd(2'd0, v);
    chk(tag, {15'b0, v[14]}, {15'b0, exp});
  endtask

  task automatic put_entry(logic [7:0] a, logic [15:0] val);
    set_ctrl(en_m, 1'b0, 1'b1, a);
    bus_wr(2'd1, val);
    tbl_m[a] = val;
    chk_busy("R4 busy during write", 1'b1);
    @(negedge clk);
    chk_busy("R4 busy after write", 1'b0);
  endtask

  task automatic host_read(logic [7:0] a, logic [15:0] exp);
    logic [15:0] v;
    set_ctrl(en_m, 1'b0, 1'b1, a);
    set_ctrl(en_m, 1'b1, 1'b1, a);
    chk_busy("R5 busy before read", 1'b0);
    @(negedge clk); chk_busy("R5 busy read cycle 1", 1'b1);
    @(negedge clk); chk_busy("R5 busy read cycle 2", 1'b1);
    @(negedge clk); chk_busy("R5 busy after read", 1'b0);
    bus_rd(2'd2, v);
    chk("R5 read data", v, exp);
  endtask

  function automatic logic [15:0] exp_col(logic [7:0] idx);
    if (own_m)       return 16'h0000;
    else if (!en_m)  return {8'h00, idx};
    else             return tbl_m[idx];
  endfunction

  task automatic send_pix(logic [7:0] idx, int gap);
    @(negedge clk);
    pix_valid = 1'b1; pix_index = idx;
    exp_q.push_back(exp_col(idx));
    if (gap > 0) begin
      @(negedge clk);
      pix_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic end_stream();
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin : monitor
    logic [15:0] e;
    if (rst_n && col_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R8 unexpected result actual=%h expected=none", col_data);
      end else begin
        e = exp_q.pop_front();
        chk("R8/R9/R10 colour result", col_data, e);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 control after reset", v, 16'h0000);
    bus_rd(2'd1, v); chk("R1 write-data after reset", v, 16'h0000);
    bus_rd(2'd2, v); chk("R1 read-data after reset", v, 16'h0000);
    send_pix(8'h05, 0);
    send_pix(8'hFF, 2);   // R9 pass-through when disabled

    // R2 reserved and busy bits not writable
    bus_wr(2'd0, 16'h7C00);
    bus_rd(2'd0, v); chk("R2 reserved bits read zero", v, 16'h0000);
    bus_wr(2'd0, 16'hFC00); en_m = 1'b1; own_m = 1'b0;
    bus_rd(2'd0, v); chk("R2 only enable kept", v, 16'h8000);

    // R3 field layout and select codes
    set_ctrl(1'b1, 1'b0, 1'b1, 8'h5A);
    bus_rd(2'd0, v); chk("R3 control layout", v, 16'h815A);
    bus_rd(2'd3, v); chk("R3 select 3 reads zero", v, 16'h0000);
    bus_wr(2'd2, 16'h1234);
    bus_rd(2'd2, v); chk("R3 read-data not writable", v, 16'h0000);

    // R12 never stalled
    chk("R12 ready while host owns", {15'b0, pix_ready}, 16'h0001);

    // R4 fill entries
    for (int i = 0; i < 16; i++) put_entry(8'(i), 16'(i * 16'h0F1D) ^ 16'hA53C);
    put_entry(8'hFF, 16'hF81F);

    // R11 write while busy dropped
    set_ctrl(1'b1, 1'b0, 1'b1, 8'd7);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd1; host_wdata = 16'h1111;
    @(negedge clk);
    chk_busy("R12 busy state check setup", 1'b1);
    chk("R12 ready while busy", {15'b0, pix_ready}, 16'h0001);
    host_sel = 2'd1; host_wdata = 16'h2222; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_sel = 2'd3;
    tbl_m[7] = 16'h1111;
    bus_rd(2'd1, v); chk("R11 write-data kept", v, 16'h1111);
    host_read(8'd7, 16'h1111);

    // R5 reads
    host_read(8'd0, tbl_m[0]);
    host_read(8'd12, tbl_m[12]);
    host_read(8'hFF, 16'hF81F);

    // R6 trigger left set: no repeat read on address change
    set_ctrl(1'b1, 1'b1, 1'b1, 8'd3);
    repeat (4) begin
      @(negedge clk); chk_busy("R6 no read while trigger held", 1'b0);
    end
    bus_rd(2'd2, v); chk("R6 read-data unchanged", v, 16'hF81F);
    host_read(8'd3, tbl_m[3]);

    // R7 display owns: writes and trigger have no effect
    set_ctrl(1'b1, 1'b0, 1'b0, 8'd2);
    bus_rd(2'd2, keep);
    bus_wr(2'd1, 16'hDEAD);
    chk_busy("R7 no busy on unowned write", 1'b0);
    set_ctrl(1'b1, 1'b1, 1'b0, 8'd2);
    repeat (3) begin
      @(negedge clk); chk_busy("R7 no read when unowned", 1'b0);
    end
    set_ctrl(1'b1, 1'b1, 1'b1, 8'd2);
    repeat (3) begin
      @(negedge clk); chk_busy("R7 spent trigger stays spent", 1'b0);
    end
    bus_rd(2'd2, v); chk("R7 read-data unchanged", v, keep);
    set_ctrl(1'b1, 1'b0, 1'b0, 8'd0);

    // R8 table lookups, back-to-back then with gaps
    for (int i = 0; i < 16; i++) send_pix(8'(i), 0);
    end_stream();
    send_pix(8'd2, 1);    // R7 entry 2 untouched by unowned write
    send_pix(8'hFF, 3);
    send_pix(8'd7, 2);

    // R10 host owns: output held at zero
    set_ctrl(1'b1, 1'b0, 1'b1, 8'd0);
    for (int i = 0; i < 4; i++) send_pix(8'(i), 0);
    end_stream();

    // R9 disabled: index passed through
    set_ctrl(1'b0, 1'b0, 1'b0, 8'd0);
    for (int i = 250; i < 256; i++) send_pix(8'(i), 0);
    end_stream();

    repeat (4) @(negedge clk);
    chk("R8 all results returned", 16'(exp_q.size()), 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule